// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution core of a small microcoded engine. It holds seven general registers. Each clock cycle, one 14-bit control word sets what the datapath does. The word picks a source for each of two operand buses, picks the ALU function that combines them, and picks the register that captures the result on the next rising clock edge. Sequencing and control storage live outside the block. The sequencer presents one word per cycle, and the datapath acts on it at once.

Either operand bus can take an external data input in place of a register. This is how values enter the register file. The ALU result is always driven on an output port with no register in the path, so results also leave the block through that port. A word whose destination code is zero only drives the output and changes no register. Such a word can read any register or pass the external input straight through. Selecting one register as both operands with exclusive-or clears it, which gives a clear operation without a constant source.

Top module: `regdp_core`

## Requirements
- R1: The control word is split by bit position: [13:11] selects the A-bus source, [10:8] selects the B-bus source, [7:5] selects the destination, and [4:0] is the ALU operation code.
- R2: A source code of 0 places `ext_in` on that bus. Source codes 1 to 7 place registers 1 to 7 on that bus.
- R3: A destination code of 0 writes no register, and all seven registers hold their values across the clock edge.
- R4: A destination code of k (1 to 7) loads register k with the ALU result on the rising clock edge. Every other register holds its value.
- R5: The arithmetic operation codes, all modulo 256, are: 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, and 00110 gives A-1.
- R6: The bitwise operation codes are: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives NOT A.
- R7: Operation code 10000 shifts A right by one bit, and operation code 11000 shifts A left by one bit. Both shifts are logical, and the vacated bit is filled with 0.
- R8: Any operation code not listed in R5 to R7 gives a result of 0.
- R9: `result_out` is combinational. It follows a change of the control word, `ext_in` or register contents in the same cycle, with no clock edge in between.
- R10: While `rst_n` is low, all registers are 0. After `rst_n` rises, a two-stage synchroniser releases the registers, so the first write that takes effect is the one at the third rising edge.
- R11: When both source fields name the same register, operation code 01100 gives 0, and a write back to that register clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| ctrl_word | input | 14 | Control word for the current cycle |
| ext_in | input | 8 | External operand, selected by source code 0 |
| result_out | output | 8 | Combinational ALU result |

## Verification
The assertions assume that `ctrl_word` and `ext_in` are stable around each rising clock edge. This matters because a load captures whatever the ALU shows at that edge. The bench changes every input on the falling edge and samples `result_out` shortly afterwards, so each value is checked well before the next capture. The write and hold properties are disabled while the synchronised reset is low. Because of this, the bench waits three edges after releasing reset before it relies on any write. All operation codes, including unlisted ones, are legal inputs.

// File: rtl/regdp_pkg.sv
package regdp_pkg;

  localparam int SEL_W  = 3;
  localparam int OP_W   = 5;
  localparam int CW_W   = 3 * SEL_W + OP_W;
  localparam int NREG   = (1 << SEL_W) - 1;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } ctrl_t;

  localparam logic [OP_W-1:0] OP_PASS = 5'b00000;
  localparam logic [OP_W-1:0] OP_INC  = 5'b00001;
  localparam logic [OP_W-1:0] OP_ADD  = 5'b00010;
  localparam logic [OP_W-1:0] OP_SUB  = 5'b00101;
  localparam logic [OP_W-1:0] OP_DEC  = 5'b00110;
  localparam logic [OP_W-1:0] OP_AND  = 5'b01000;
  localparam logic [OP_W-1:0] OP_OR   = 5'b01010;
  localparam logic [OP_W-1:0] OP_XOR  = 5'b01100;
  localparam logic [OP_W-1:0] OP_NOT  = 5'b01110;
  localparam logic [OP_W-1:0] OP_SHR  = 5'b10000;
  localparam logic [OP_W-1:0] OP_SHL  = 5'b11000;

endpackage

// File: rtl/regdp_regfile.sv
module regdp_regfile
  import regdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  regs_q
);

  logic [NREG-1:0]          wr_en;
  logic [NREG-1:0][DW-1:0]  regs_d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [SEL_W-1:0] CODE = SEL_W'(i + 1);

    always_comb begin
      wr_en[i]  = (wr_sel == CODE);
      regs_d[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[i] <= '0;
      else if (wr_en[i]) regs_q[i] <= regs_d[i];
    end

    // R4
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel == CODE) |=> (regs_q[i] == $past(wr_data)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel != CODE) |=> $stable(regs_q[i]));
  end

endmodule

// File: rtl/regdp_opsel.sv
module regdp_opsel
  import regdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [DW-1:0]            ext,
  input  logic [NREG-1:0][DW-1:0]  regs,
  output logic [DW-1:0]            bus
);

  always_comb begin
    bus = ext;
    for (int i = 0; i < NREG; i++) begin
      if (sel == SEL_W'(i + 1)) bus = regs[i];
    end
  end

endmodule

// File: rtl/regdp_alu.sv
module regdp_alu
  import regdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    unique case (op)
      OP_PASS: y = a;
      OP_INC:  y = a + ONE;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_DEC:  y = a - ONE;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHR:  y = {1'b0, a[DW-1:1]};
      OP_SHL:  y = {a[DW-2:0], 1'b0};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/regdp_core.sv
module regdp_core
  import regdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [DW-1:0]   ext_in,
  output logic [DW-1:0]   result_out
);

  ctrl_t                    cw;
  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [NREG-1:0][DW-1:0]  regs_q;
  logic [DW-1:0]            bus_a;
  logic [DW-1:0]            bus_b;
  logic [DW-1:0]            alu_y;

  assign cw = ctrl_t'(ctrl_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  regdp_regfile #(.DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_sel  (cw.dst),
    .wr_data (alu_y),
    .regs_q  (regs_q)
  );

  regdp_opsel #(.DW(DW)) u_sel_a (
    .sel  (cw.src_a),
    .ext  (ext_in),
    .regs (regs_q),
    .bus  (bus_a)
  );

  regdp_opsel #(.DW(DW)) u_sel_b (
    .sel  (cw.src_b),
    .ext  (ext_in),
    .regs (regs_q),
    .bus  (bus_b)
  );

  regdp_alu #(.DW(DW)) u_alu (
    .op (cw.op),
    .a  (bus_a),
    .b  (bus_b),
    .y  (alu_y)
  );

  assign result_out = alu_y;

  // R2
  a_ext_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cw.src_a == '0) |-> (bus_a == ext_in));

  // R2
  b_ext_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cw.src_b == '0) |-> (bus_b == ext_in));

  // R11
  xor_self_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cw.op == OP_XOR && cw.src_a == cw.src_b) |-> (result_out == '0));

  // R5
  pass_out_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cw.op == OP_PASS) |-> (result_out == bus_a));

endmodule

// File: tb/regdp_core_test.sv
module regdp_core_test;

  logic        clk;
  logic        rst_n;
  logic [13:0] ctrl_word;
  logic [7:0]  ext_in;
  logic [7:0]  result_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  regdp_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_word  (ctrl_word),
    .ext_in     (ext_in),
    .result_out (result_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [13:0] cwf(input int a, input int b, input int d,
                                      input logic [4:0] op);
    return {3'(a), 3'(b), 3'(d), op};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (result_out !== exp) begin
      bad++;
      $display("FAIL %s: result_out=%02h expected=%02h", req, result_out, exp);
    end
  endtask

  task automatic apply(input logic [13:0] cw, input logic [7:0] x);
    @(negedge clk);
    ctrl_word = cw;
    ext_in    = x;
    #1;
  endtask

  // entry: {req, src_a, src_b, dst, op, ext, expected}
  localparam int NV = 26;
  localparam logic [33:0] VEC [NV] = '{
    {4'd2,  3'd0, 3'd0, 3'd1, 5'b00000, 8'h3C, 8'h3C}, // R2 R4 load R1
    {4'd2,  3'd0, 3'd0, 3'd2, 5'b00000, 8'hA5, 8'hA5}, // load R2
    {4'd2,  3'd0, 3'd0, 3'd3, 5'b00000, 8'h81, 8'h81}, // load R3
    {4'd2,  3'd0, 3'd0, 3'd4, 5'b00000, 8'hFF, 8'hFF}, // load R4
    {4'd2,  3'd0, 3'd0, 3'd5, 5'b00000, 8'h0F, 8'h0F}, // load R5
    {4'd5,  3'd1, 3'd2, 3'd6, 5'b00010, 8'h00, 8'hE1}, // R5 add into R6
    {4'd5,  3'd2, 3'd1, 3'd7, 5'b00101, 8'h00, 8'h69}, // R5 sub into R7
    {4'd5,  3'd1, 3'd0, 3'd1, 5'b00001, 8'h00, 8'h3D}, // R5 inc R1
    {4'd3,  3'd4, 3'd0, 3'd0, 5'b00001, 8'h00, 8'h00}, // R3 wrap, no write
    {4'd5,  3'd3, 3'd0, 3'd0, 5'b00110, 8'h00, 8'h80}, // R5 dec
    {4'd6,  3'd2, 3'd5, 3'd0, 5'b01000, 8'h00, 8'h05}, // R6 and
    {4'd6,  3'd1, 3'd5, 3'd0, 5'b01010, 8'h00, 8'h3F}, // R6 or
    {4'd6,  3'd2, 3'd4, 3'd0, 5'b01100, 8'h00, 8'h5A}, // R6 xor
    {4'd6,  3'd1, 3'd0, 3'd0, 5'b01110, 8'h00, 8'hC2}, // R6 complement
    {4'd7,  3'd3, 3'd0, 3'd0, 5'b10000, 8'h00, 8'h40}, // R7 shift right
    {4'd7,  3'd3, 3'd0, 3'd0, 5'b11000, 8'h00, 8'h02}, // R7 shift left
    {4'd8,  3'd4, 3'd4, 3'd0, 5'b00011, 8'h00, 8'h00}, // R8 unlisted
    {4'd8,  3'd4, 3'd4, 3'd0, 5'b11111, 8'h00, 8'h00}, // R8 unlisted
    {4'd5,  3'd1, 3'd2, 3'd0, 5'b00101, 8'h00, 8'h98}, // R5 sub borrow
    {4'd11, 3'd5, 3'd5, 3'd5, 5'b01100, 8'h00, 8'h00}, // R11 clear R5
    {4'd11, 3'd5, 3'd0, 3'd0, 5'b00000, 8'h00, 8'h00}, // R11 R5 now zero
    {4'd4,  3'd6, 3'd0, 3'd0, 5'b00000, 8'h00, 8'hE1}, // R4 R6 held sum
    {4'd4,  3'd7, 3'd0, 3'd0, 5'b00000, 8'h00, 8'h69}, // R4 R7 held diff
    {4'd3,  3'd4, 3'd0, 3'd0, 5'b00000, 8'h00, 8'hFF}, // R3 R4 untouched
    {4'd2,  3'd0, 3'd7, 3'd0, 5'b00010, 8'h01, 8'h6A}, // R2 ext on A, R7 on B
    {4'd1,  3'd0, 3'd0, 3'd0, 5'b00110, 8'h00, 8'hFF}  // R1 fields, dec wrap
  };

  initial begin
    #800000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: result_out=%02h expected=finish", result_out);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    ctrl_word = '0;
    ext_in    = '0;
    repeat (3) @(negedge clk);

    // R10 registers read zero while in reset and after release
    for (int k = 1; k <= 7; k++) begin
      apply(cwf(k, 0, 0, 5'b00000), 8'h00);
      check("R10", 8'h00);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 1; k <= 7; k++) begin
      apply(cwf(k, 0, 0, 5'b00000), 8'h00);
      check("R10", 8'h00);
    end

    // R9: each check samples 1 ns after the inputs change, before any edge
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][29:16], VEC[v][15:8]);
      total++;
      if (result_out !== VEC[v][7:0]) begin
        bad++;
        $display("FAIL R%0d vec %0d: result_out=%02h expected=%02h",
                 VEC[v][33:30], v, result_out, VEC[v][7:0]);
      end
    end

    // R9 ext change seen without a clock edge
    @(negedge clk);
    ctrl_word = cwf(0, 0, 0, 5'b00000);
    ext_in    = 8'h11;
    #1 check("R9", 8'h11);
    ext_in = 8'h77;
    #1 check("R9", 8'h77);

    // R10 reset mid-run, then writes ignored until the third edge
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    apply(cwf(6, 0, 0, 5'b00000), 8'h00);
    check("R10", 8'h00);
    ctrl_word = cwf(0, 0, 1, 5'b00000);
    ext_in    = 8'h55;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ctrl_word = cwf(1, 0, 0, 5'b00000);
    #1 check("R10", 8'h00);
    apply(cwf(0, 0, 1, 5'b00000), 8'h55);
    apply(cwf(1, 0, 0, 5'b00000), 8'h00);
    check("R10", 8'h55);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule